// File: doc/BRIEF.md
# SPI flash command sequencer

This block runs complete SPI NOR flash operations for a host. The host issues one command at a time with an operation code, a 24-bit flash address and a byte length. The sequencer then drives a byte-level SPI master: it raises a chip-select level, presents one byte at a time, and takes back the byte the flash returned. The block itself generates the opcodes, the address bytes, the dummy bytes and the chip-select framing.

There are four operations: read the JEDEC identity, stream a data range back to the host, erase a sector, and program one page. Before an erase or a program, the block sets the write-enable latch and then reads status to confirm it. After the erase or program, it polls the busy bit until it clears. Between polls it waits a gap counted in millisecond ticks, and it fails when a millisecond budget runs out. Before a program, the page data is first loaded into a local buffer. A page that holds only 0xFF bytes finishes without any flash access.

Each command ends with a single-cycle `done` pulse and a 3-bit result code. The code values are 0 for none, 1 for write-enable failure, 2 for timeout, 3 for misaligned, 4 for oversize and 5 for no device.

Top module: `sflash_seq`

## Requirements
- R1: Every address goes out as three bytes after the opcode, highest byte first. The opcodes are 0x03 for read, 0x02 for page program and 0x20 for sector erase.
- R2: An erase or a program first sends a one-byte frame 0x06. It then sends a two-byte status frame (0x05, 0x00). If bit 1 of the returned status is clear, the command ends with code 1 and sends no further frame.
- R3: After the erase or program frame, the block repeats the status frame while bit 0 of the status is set. It waits POLL_GAP_MS ticks between polls. It ends with code 2 once TIMEOUT_MS ticks have elapsed since polling began, and with code 0 when bit 0 reads clear.
- R4: A read or program whose address has a nonzero offset within a page (low 8 bits) ends with code 3 and sends no SPI traffic.
- R5: A program whose length exceeds PAGE_BYTES ends with code 4 and sends no SPI traffic.
- R6: A program whose loaded bytes are all 0xFF (including length 0) ends with code 0 and sends no SPI traffic.
- R7: An ID read sends 0x9F followed by three 0x00 bytes. `dev_id` is set to {third, second, first} returned byte. A result of 0xFFFFFF ends with code 5; any other result ends with code 0.
- R8: A read or a program keeps chip select asserted, as one frame, from the opcode to its last data byte. Chip select drops in the cycle after the final byte is acknowledged.
- R9: A read returns exactly `cmd_len` bytes on `rd_valid`/`rd_data`, in flash order, after the four header bytes. During the data phase the bytes sent are 0x00.
- R10: `cmd_ready` is high only when no command is in progress, and `done` is a single-cycle pulse.
- R11: `spi_req` is asserted only together with `spi_cs`. While it waits for `spi_ack`, both `spi_req` and `spi_tx` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is high |
| cmd_ready | output | 1 | Sequencer idle |
| cmd_op | input | 2 | 0 ID, 1 read, 2 erase, 3 program |
| cmd_addr | input | 24 | Flash byte address |
| cmd_len | input | LEN_W | Byte count of read or program |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Program buffer accepting bytes |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | Command finished pulse |
| err_code | output | 3 | Result code of the last command |
| dev_id | output | 24 | Assembled identity |
| spi_cs | output | 1 | Chip select, active high |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte received |

## Verification
The assertions assume that the SPI master answers a request with a single-cycle `spi_ack` and never acknowledges without a pending request. They also assume that the host raises `cmd_valid` only while `cmd_ready` is high. The bench's flash model meets the first assumption: it acknowledges one negative edge after it sees a request and drops the acknowledge on the next negative edge. The command task meets the second: it raises the strobe for one cycle, only when the sequencer is idle, and offers program bytes only while `wr_ready` is high.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  typedef enum logic [1:0] {OP_ID = 2'd0, OP_READ = 2'd1, OP_ERASE = 2'd2, OP_PROG = 2'd3} op_e;
  typedef enum logic [2:0] {E_NONE = 3'd0, E_WEL = 3'd1, E_TMO = 3'd2, E_ALIGN = 3'd3,
                            E_SIZE = 3'd4, E_NODEV = 3'd5} err_e;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_SEP, S_GAP} st_e;
  typedef enum logic [1:0] {P_WREN, P_WECHK, P_MAIN, P_POLL} ph_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_ERAS = 8'h20;
  localparam logic [7:0] OPC_JDID = 8'h9F;

  // header slot 0..2 carries address bits 23:16, 15:8, 7:0
  function automatic logic [7:0] addr_slot(logic [23:0] a, logic [1:0] slot);
    case (slot)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  function automatic logic [7:0] main_opcode(op_e op);
    case (op)
      OP_ID:    return OPC_JDID;
      OP_READ:  return OPC_READ;
      OP_ERASE: return OPC_ERAS;
      default:  return OPC_PROG;
    endcase
  endfunction
endpackage

// File: rtl/sfq_page_buf.sv
module sfq_page_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int PA_W = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [PA_W-1:0] waddr,
  input  logic [7:0]      wdata,
  input  logic [PA_W-1:0] raddr,
  output logic [7:0]      rdata,
  output logic            all_ff
);
  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   all_ff <= 1'b1;
    else if (clr) all_ff <= 1'b1;
    else if (we)  all_ff <= all_ff && (wdata == 8'hFF);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfq_poll_timer.sv
module sfq_poll_timer #(
  parameter int TIMEOUT_MS  = 3000,
  parameter int POLL_GAP_MS = 1,
  localparam int TMO_W = $clog2(TIMEOUT_MS + 1),
  localparam int GAP_W = $clog2(POLL_GAP_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic restart,
  input  logic gap_start,
  output logic expired,
  output logic gap_done
);
  logic [TMO_W-1:0] elapsed_q;
  logic [GAP_W-1:0] gap_q;

  assign expired  = elapsed_q >= TMO_W'(TIMEOUT_MS);
  assign gap_done = gap_q >= GAP_W'(POLL_GAP_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      gap_q     <= '0;
    end else begin
      if (restart)                  elapsed_q <= '0;
      else if (ms_tick && !expired) elapsed_q <= elapsed_q + 1'b1;
      if (gap_start)                gap_q <= '0;
      else if (ms_tick && !gap_done) gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfq_frame_gen.sv
module sfq_frame_gen
  import sfq_pkg::*;
#(
  parameter int LEN_W = 9,
  localparam int BI_W = LEN_W + 1
) (
  input  ph_e              ph,
  input  op_e              op,
  input  logic [BI_W-1:0]  bi,
  input  logic [23:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       page_byte,
  output logic [7:0]       tx,
  output logic [BI_W-1:0]  flen
);
  logic [BI_W-1:0] slot;
  assign slot = bi - BI_W'(1);

  always_comb begin
    case (ph)
      P_WREN:  flen = BI_W'(1);
      P_MAIN:  flen = (op == OP_READ || op == OP_PROG) ? BI_W'(4) + BI_W'(len) : BI_W'(4);
      default: flen = BI_W'(2);
    endcase
  end

  always_comb begin
    tx = 8'h00;
    case (ph)
      P_WREN: tx = OPC_WREN;
      P_MAIN: begin
        if (bi == '0)                   tx = main_opcode(op);
        else if (bi < BI_W'(4))         tx = (op == OP_ID) ? 8'h00 : addr_slot(addr, slot[1:0]);
        else if (op == OP_PROG)         tx = page_byte;
      end
      default: tx = (bi == '0) ? OPC_RDSR : 8'h00;
    endcase
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfq_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int TIMEOUT_MS  = 3000,
  parameter int POLL_GAP_MS = 1,
  localparam int LEN_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [23:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [2:0]       err_code,
  output logic [23:0]      dev_id,
  output logic             spi_cs,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx
);
  localparam int PA_W = $clog2(PAGE_BYTES);
  localparam int BI_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  st_e              state_q;
  ph_e              ph_q;
  op_e              op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q, ld_q;
  logic [BI_W-1:0]  bi_q, flen;
  logic [7:0]       stat_q, page_byte;
  logic [23:0]      id_q;
  err_e             err_q, reject;
  logic             done_q, rdv_q;
  logic [7:0]       rdd_q;

  // named internal events
  logic cmd_fire, reject_hit, frame_end, load_full, buf_we, all_ff;
  logic poll_restart, gap_start, tmo_expired, gap_done, busy_bit, wel_bit;
  logic [BI_W-1:0] data_idx;

  assign cmd_fire   = (state_q == S_IDLE) && cmd_valid;
  assign load_full  = (ld_q == len_q);
  assign buf_we     = (state_q == S_LOAD) && !load_full && wr_valid;
  assign frame_end  = (state_q == S_XFER) && spi_ack && (bi_q == flen - BI_W'(1));
  assign busy_bit   = stat_q[0];
  assign wel_bit    = stat_q[1];
  assign poll_restart = (state_q == S_SEP) && (ph_q == P_MAIN) &&
                        (op_q == OP_ERASE || op_q == OP_PROG);
  assign gap_start  = (state_q == S_SEP) && (ph_q == P_POLL) && busy_bit && !tmo_expired;
  assign data_idx   = bi_q - BI_W'(4);

  always_comb begin
    reject = E_NONE;
    if ((op_e'(cmd_op) == OP_READ || op_e'(cmd_op) == OP_PROG) && cmd_addr[PA_W-1:0] != '0)
      reject = E_ALIGN;
    else if (op_e'(cmd_op) == OP_PROG && cmd_len > PAGE_L)
      reject = E_SIZE;
  end
  assign reject_hit = cmd_fire && (reject != E_NONE);

  sfq_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .we(buf_we),
    .waddr(ld_q[PA_W-1:0]), .wdata(wr_data),
    .raddr(data_idx[PA_W-1:0]), .rdata(page_byte), .all_ff(all_ff));

  sfq_poll_timer #(.TIMEOUT_MS(TIMEOUT_MS), .POLL_GAP_MS(POLL_GAP_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .restart(poll_restart),
    .gap_start(gap_start), .expired(tmo_expired), .gap_done(gap_done));

  sfq_frame_gen #(.LEN_W(LEN_W)) u_frm (
    .ph(ph_q), .op(op_q), .bi(bi_q), .addr(addr_q), .len(len_q),
    .page_byte(page_byte), .tx(spi_tx), .flen(flen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  ph_q <= P_WREN;  op_q <= OP_ID;
      addr_q  <= '0;      len_q <= '0;     ld_q <= '0;    bi_q <= '0;
      stat_q  <= '0;      id_q <= '0;      err_q <= E_NONE;
      done_q  <= 1'b0;    rdv_q <= 1'b0;   rdd_q <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q <= op_e'(cmd_op);  addr_q <= cmd_addr;  len_q <= cmd_len;
          ld_q <= '0;             bi_q <= '0;
          if (reject != E_NONE) begin
            done_q <= 1'b1;  err_q <= reject;
          end else if (op_e'(cmd_op) == OP_PROG) begin
            state_q <= S_LOAD;
          end else begin
            state_q <= S_XFER;
            ph_q    <= (op_e'(cmd_op) == OP_ERASE) ? P_WREN : P_MAIN;
          end
        end
        S_LOAD: begin
          if (load_full) begin
            if (all_ff) begin
              done_q <= 1'b1;  err_q <= E_NONE;  state_q <= S_IDLE;
            end else begin
              state_q <= S_XFER;  ph_q <= P_WREN;
            end
          end else if (wr_valid) ld_q <= ld_q + 1'b1;
        end
        S_XFER: if (spi_ack) begin
          if (bi_q == BI_W'(1)) stat_q <= spi_rx;
          if (ph_q == P_MAIN && op_q == OP_ID && bi_q != '0) id_q <= {spi_rx, id_q[23:8]};
          if (ph_q == P_MAIN && op_q == OP_READ && bi_q >= BI_W'(4)) begin
            rdv_q <= 1'b1;  rdd_q <= spi_rx;
          end
          if (frame_end) begin
            bi_q <= '0;  state_q <= S_SEP;
          end else bi_q <= bi_q + 1'b1;
        end
        S_SEP: begin
          state_q <= S_XFER;
          case (ph_q)
            P_WREN:  ph_q <= P_WECHK;
            P_WECHK: if (wel_bit) ph_q <= P_MAIN;
                     else begin done_q <= 1'b1; err_q <= E_WEL; state_q <= S_IDLE; end
            P_MAIN:  if (op_q == OP_ERASE || op_q == OP_PROG) ph_q <= P_POLL;
                     else begin
                       done_q  <= 1'b1;  state_q <= S_IDLE;
                       err_q   <= (op_q == OP_ID && id_q == 24'hFFFFFF) ? E_NODEV : E_NONE;
                     end
            default: if (!busy_bit) begin done_q <= 1'b1; err_q <= E_NONE; state_q <= S_IDLE; end
                     else if (tmo_expired) begin done_q <= 1'b1; err_q <= E_TMO; state_q <= S_IDLE; end
                     else state_q <= S_GAP;
          endcase
        end
        S_GAP:   if (gap_done) state_q <= S_XFER;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign wr_ready  = (state_q == S_LOAD) && !load_full;
  assign spi_cs    = (state_q == S_XFER);
  assign spi_req   = (state_q == S_XFER);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign done      = done_q;
  assign err_code  = err_q;
  assign dev_id    = id_q;
endmodule

// File: rtl/sfq_chk.sv
module sfq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs,
  input logic       spi_req,
  input logic       spi_ack,
  input logic [7:0] spi_tx,
  input logic       done,
  input logic [2:0] err_code,
  input logic       rd_valid,
  input logic       cmd_ready,
  input logic       reject_hit,
  input logic       frame_end,
  input logic       tmo_expired
);
  AST_REQ_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> spi_cs); // R11
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_tx)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reject_hit |=> done && !spi_cs && cmd_ready); // R4
  AST_CS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !spi_cs); // R8
  AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_code == 3'd2 |-> tmo_expired); // R3
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready); // R9
endmodule

bind sflash_seq sfq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_req(spi_req), .spi_ack(spi_ack),
  .spi_tx(spi_tx), .done(done), .err_code(err_code), .rd_valid(rd_valid),
  .cmd_ready(cmd_ready), .reject_hit(reject_hit), .frame_end(frame_end),
  .tmo_expired(tmo_expired));

// File: tb/sflash_seq_test.sv
module sflash_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [23:0] cmd_addr = '0;
  logic [8:0] cmd_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, done, spi_cs, spi_req;
  logic [7:0] rd_data, spi_tx;
  logic [2:0] err_code;
  logic [23:0] dev_id;
  logic spi_ack = 1'b0;
  logic [7:0] spi_rx = '0;

  sflash_seq uut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int nchk = 0, nerr = 0;
  int nbytes = 0, nframes = 0, nrd = 0, fpos = 0, tickc = 0;
  logic [7:0] fop = '0;
  logic [23:0] faddr = '0;
  logic [7:0] logb [0:1023];
  logic [7:0] rdb  [0:511];
  logic [7:0] pbuf [0:511];
  logic wel_resp = 1'b1, busy_forever = 1'b0;
  int busy_left = 0;
  logic [7:0] idb [0:2];

  function automatic logic [7:0] patt(logic [23:0] a);
    return 8'(a ^ (a >> 8) ^ (a >> 16)) + 8'h3C;
  endfunction

  always @(negedge clk) begin
    tickc = (tickc + 1) % 4;
    ms_tick <= (tickc == 0);
  end

  // flash model behind the byte interface
  always @(negedge clk) begin
    if (!spi_cs) fpos = 0;
    if (spi_ack) spi_ack <= 1'b0;
    else if (spi_req) begin
      if (fpos == 0) begin fop = spi_tx; nframes++; end
      if (fpos >= 1 && fpos <= 3) faddr = {faddr[15:0], spi_tx};
      if (nbytes < 1024) logb[nbytes] = spi_tx;
      nbytes++;
      spi_rx <= 8'h00;
      if (fop == 8'h05 && fpos == 1) begin
        spi_rx <= {6'b0, wel_resp, busy_forever || busy_left > 0};
        if (busy_left > 0) busy_left--;
      end else if (fop == 8'h9F && fpos >= 1 && fpos <= 3) spi_rx <= idb[fpos-1];
      else if (fop == 8'h03 && fpos >= 4) spi_rx <= patt(faddr + 24'(fpos - 4));
      spi_ack <= 1'b1;
      fpos++;
    end
  end

  always @(negedge clk) if (rd_valid) begin
    if (nrd < 512) rdb[nrd] = rd_data;
    nrd++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [23:0] a, input int n);
    int k = 0, wd = 0;
    nbytes = 0; nframes = 0; nrd = 0;
    @(negedge clk);
    cmd_valid <= 1'b1; cmd_op <= op; cmd_addr <= a; cmd_len <= 9'(n);
    @(negedge clk);
    cmd_valid <= 1'b0;
    while (!done && wd < 60000) begin
      if (wr_ready && k < n) begin wr_valid <= 1'b1; wr_data <= pbuf[k]; k++; end
      else wr_valid <= 1'b0;
      @(negedge clk);
      wd++;
    end
    wr_valid <= 1'b0;
    if (wd >= 60000) begin nerr++; nchk++; $display("FAIL watchdog op %0d", op); end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    nerr++;
    $display("FAIL global watchdog");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int ok;
    repeat (3) @(negedge clk);
    chk("R10 ready after reset", cmd_ready, 1);
    chk("R10 done low after reset", done, 0);
    chk("R11 cs low after reset", spi_cs, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 identity
    idb[0] = 8'hAB; idb[1] = 8'hCD; idb[2] = 8'hEF;
    do_cmd(2'd0, 24'h0, 0);
    chk("R7 id value", dev_id, 24'hEFCDAB);
    chk("R7 id code", err_code, 0);
    chk("R7 id bytes", {logb[0], logb[1], logb[2], logb[3]}, 32'h9F000000);
    chk("R7 id frames", nframes, 1);
    idb[0] = 8'hFF; idb[1] = 8'hFF; idb[2] = 8'hFF;
    do_cmd(2'd0, 24'h0, 0);
    chk("R7 no device", err_code, 5);

    // R1 R8 R9 read sweep
    for (int ai = 0; ai < 3; ai++) begin
      for (int n = 0; n <= 8; n++) begin
        logic [23:0] a;
        a = (ai == 0) ? 24'h000000 : (ai == 1) ? 24'h123400 : 24'hFFFF00;
        do_cmd(2'd1, a, n);
        ok = (nframes == 1) && (nbytes == 4 + n) && (nrd == n) && (err_code == 0) &&
             logb[0] == 8'h03 && logb[1] == a[23:16] && logb[2] == a[15:8] && logb[3] == a[7:0];
        for (int i = 0; i < n; i++)
          if (rdb[i] != patt(a + 24'(i)) || logb[4+i] != 8'h00) ok = 0;
        chk($sformatf("R1 R8 R9 read a=%h n=%0d", a, n), ok, 1);
      end
    end

    // R4 misaligned read and program
    do_cmd(2'd1, 24'h000010, 4);
    chk("R4 read misaligned code", err_code, 3);
    chk("R4 read misaligned quiet", nbytes, 0);
    for (int i = 0; i < 4; i++) pbuf[i] = 8'h11;
    do_cmd(2'd3, 24'h000201, 4);
    chk("R4 program misaligned code", err_code, 3);
    chk("R4 program misaligned quiet", nbytes, 0);

    // R5 oversize
    do_cmd(2'd3, 24'h000300, 300);
    chk("R5 oversize code", err_code, 4);
    chk("R5 oversize quiet", nbytes, 0);

    // R2 R3 erase, one busy reply consumed by the enable check, then 3 busy polls
    busy_left = 4;
    do_cmd(2'd2, 24'h0A0B0C, 0);
    chk("R3 erase code", err_code, 0);
    chk("R2 R3 erase frames", nframes, 7);
    chk("R2 enable then status", {logb[0], logb[1], logb[2]}, {8'h06, 8'h05, 8'h00});
    chk("R1 erase header", {logb[3], logb[4], logb[5], logb[6]}, 32'h200A0B0C);
    chk("R3 poll opcode", logb[7], 8'h05);

    wel_resp = 1'b0;
    do_cmd(2'd2, 24'h000000, 0);
    chk("R2 enable failure code", err_code, 1);
    chk("R2 enable failure frames", nframes, 2);
    wel_resp = 1'b1;

    busy_forever = 1'b1;
    do_cmd(2'd2, 24'h001000, 0);
    chk("R3 timeout code", err_code, 2);
    busy_forever = 1'b0;

    // R6 R8 program sweep
    for (int n = 0; n <= 8; n++) begin
      for (int i = 0; i < n; i++) pbuf[i] = 8'hFF;
      do_cmd(2'd3, 24'h004500, n);
      chk($sformatf("R6 all ones n=%0d", n), {err_code, 8'(nbytes)}, {3'd0, 8'd0});
      if (n > 0) begin
        logic [23:0] a;
        a = 24'h040000 + 24'(n) * 24'h100;
        for (int i = 0; i < n; i++) pbuf[i] = (i == n - 1) ? 8'h7E : 8'hFF;
        if (n > 2) pbuf[0] = 8'(n * 17);
        busy_left = 1;
        do_cmd(2'd3, a, n);
        ok = (err_code == 0) && (nframes == 4) && (nbytes == 3 + 4 + n + 2) &&
             logb[0] == 8'h06 && logb[1] == 8'h05 && logb[3] == 8'h02 &&
             logb[4] == a[23:16] && logb[5] == a[15:8] && logb[6] == a[7:0];
        for (int i = 0; i < n; i++) if (logb[7+i] != pbuf[i]) ok = 0;
        chk($sformatf("R1 R8 program n=%0d", n), ok, 1);
      end
    end

    // full page program
    for (int i = 0; i < 256; i++) pbuf[i] = 8'(i * 3 + 1);
    do_cmd(2'd3, 24'h7F0000, 256);
    ok = (err_code == 0) && (nframes == 4) && (nbytes == 3 + 4 + 256 + 2);
    for (int i = 0; i < 256; i++) if (logb[7+i] != pbuf[i]) ok = 0;
    chk("R8 full page program", ok, 1);
    chk("R10 ready after commands", cmd_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule